// File: doc/BRIEF.md
# Regulator Power Sequencer with Fault Recovery

This block is the digital sequencer for a step-up/step-down switching regulator. It watches an external enable input and a set of already-conditioned analog flags (input undervoltage, die over-temperature, peak current limit, output within regulation), together with a bypass request. It decides when the power stage may switch, when the input-to-output path must be isolated, when the output discharge resistor is connected and when the power-good line is pulled low. It also produces the reference code fed to the regulation loop, ramped one step at a time from zero toward the programmed target.

All timing is counted in ticks of a one-microsecond strobe, so the block runs on any system clock that is fast enough to see every strobe. A start-up deadline, a current-limit persistence window and a recovery wait are each set by a parameter, and after a fault the block tries to start again by itself once the wait is over and the conditions allow.

Top module: `reg_seq_ctrl`

## Requirements
- R1: After reset and whenever the block is off, `sw_en`=0, `iso_req`=1, `dis_en`=1, `pg_pull_low`=0 (power-good left floating) and `ref_code`=0.
- R2: `en_pin` low sends the block to the off state at the next clock edge from any state, ahead of every other condition, including a fault decided on the same edge.
- R3: A rising `en_pin` (no undervoltage or over-temperature) starts soft start: `sw_en`=1, `iso_req`=0, `pg_pull_low`=1, and `ref_code` starts at 0 and moves one code toward `target_code` on every `RAMP_DIV`-th tick.
- R4: Soft start ends at the first edge at which `ref_code` equals `target_code` and `out_ok` is high; then `pg_pull_low` drops to 0 and the block regulates (`sw_en`=1, `iso_req`=0).
- R5: If soft start has not ended after `SS_TICKS` ticks, a fault follows at the next edge; when completion and expiry fall on the same edge, completion wins.
- R6: `ilim` high for `OCP_TICKS` consecutive ticks in soft start or regulation causes a fault at the next edge; one cycle of `ilim` low restarts the count.
- R7: `uvlo` or `otp` high in soft start, regulation or bypass causes a fault at the next edge.
- R8: In fault, `sw_en`=0, `iso_req`=1, `pg_pull_low`=1, `ref_code`=0, and `dis_en` stays 0.
- R9: After `RETRY_TICKS` ticks in fault the block re-enters soft start, but only while `en_pin` is high and `uvlo` and `otp` are low; otherwise it waits in fault until they are.
- R10: `pass_thru` high in regulation (or at soft-start completion) selects bypass: `sw_en`=0, `iso_req`=0, `pg_pull_low`=0; `ilim` has no effect there; `pass_thru` low returns to regulation.
- R11: In regulation, a change of `target_code` is followed by `ref_code` one code per `RAMP_DIV` ticks, up or down.
- R12: With `tick_us` low no timer or ramp advances: `ref_code` holds and no timeout fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| en_pin | input | 1 | External enable, synchronised |
| uvlo | input | 1 | Input undervoltage flag, hysteresis already applied |
| otp | input | 1 | Die over-temperature flag |
| ilim | input | 1 | Peak current limit active |
| out_ok | input | 1 | Output has reached its target band |
| pass_thru | input | 1 | Bypass request from the control register |
| target_code | input | CODE_W | Programmed output reference code |
| sw_en | output | 1 | Power stage allowed to switch |
| ref_code | output | CODE_W | Ramped reference code to the loop |
| dis_en | output | 1 | Connect the output discharge resistor |
| iso_req | output | 1 | Put the input-to-output path in high impedance |
| pg_pull_low | output | 1 | Drive the open-drain power-good line low |

## Verification
Two pairs of events can land on one edge. The enable line falling on the very cycle in which the current-limit window expires is provoked by holding `ilim` for exactly `OCP_TICKS` ticks and dropping `en_pin` before the deciding edge; the result must be the off state with discharge on, not a fault. The soft-start deadline meeting completion is provoked by holding `out_ok` low with the ramp already at target and raising it just before the expiry edge; the result must be regulation with power-good released.

// File: rtl/reg_seq_pkg.sv
package reg_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SOFT   = 3'd1,
    ST_RUN    = 3'd2,
    ST_BYPASS = 3'd3,
    ST_FAULT  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic sw_en;
    logic iso_req;
    logic dis_en;
    logic pg_pull_low;
  } seq_outs_t;

endpackage

// File: rtl/seq_timer.sv
// Saturating tick counter with synchronous clear.
module seq_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv && (cnt_q != {W{1'b1}})) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/seq_ramp.sv
// Reference ramp: one code toward the target every DIV ticks while running.
module seq_ramp #(
  parameter int CW  = 7,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic [CW-1:0] code,
  output logic          at_target
);

  logic          step;
  logic [CW-1:0] code_q, code_d;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign step = run && tick;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        pre_d = pre_q;
        if (clr) begin
          pre_d = '0;
        end else if (run && tick) begin
          pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_d;
        end
      end

      assign step = run && tick && (pre_q == LAST);
    end
  endgenerate

  always_comb begin
    code_d = code_q;
    if (clr) begin
      code_d = '0;
    end else if (step && (code_q < target)) begin
      code_d = code_q + 1'b1;
    end else if (step && (code_q > target)) begin
      code_d = code_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_d;
    end
  end

  assign code      = code_q;
  assign at_target = (code_q == target);

endmodule

// File: rtl/reg_seq_ctrl.sv
module reg_seq_ctrl
  import reg_seq_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int SS_TICKS    = 1000,
  parameter int OCP_TICKS   = 700,
  parameter int RETRY_TICKS = 30000,
  parameter int RAMP_DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              en_pin,
  input  logic              uvlo,
  input  logic              otp,
  input  logic              ilim,
  input  logic              out_ok,
  input  logic              pass_thru,
  input  logic [CODE_W-1:0] target_code,
  output logic              sw_en,
  output logic [CODE_W-1:0] ref_code,
  output logic              dis_en,
  output logic              iso_req,
  output logic              pg_pull_low
);

  localparam int PH_MAX = (SS_TICKS > RETRY_TICKS) ? SS_TICKS : RETRY_TICKS;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int OC_W   = $clog2(OCP_TICKS + 1);
  localparam logic [PH_W-1:0] SS_LIM  = PH_W'(SS_TICKS);
  localparam logic [PH_W-1:0] RT_LIM  = PH_W'(RETRY_TICKS);
  localparam logic [OC_W-1:0] OCP_LIM = OC_W'(OCP_TICKS);

  seq_state_e    state_q, state_d;
  logic [PH_W-1:0] phase_cnt;
  logic [OC_W-1:0] ocp_cnt;
  logic            ramp_done;
  logic            ramp_clr, ramp_run;
  logic            ocp_watch, ocp_trip;
  logic            ss_expired, retry_expired, hard_fault;
  seq_outs_t       outs;

  // Phase timer: restarts on every state change.
  seq_timer #(.W(PH_W)) u_phase_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_d != state_q),
    .adv   (tick_us),
    .cnt   (phase_cnt)
  );

  // Current-limit persistence: only while switching under regulation.
  assign ocp_watch = (state_q == ST_SOFT) || (state_q == ST_RUN);

  seq_timer #(.W(OC_W)) u_ocp_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!ilim || !ocp_watch),
    .adv   (tick_us),
    .cnt   (ocp_cnt)
  );

  assign ramp_clr = (state_d == ST_OFF) || (state_d == ST_FAULT);
  assign ramp_run = (state_q == ST_SOFT) || (state_q == ST_RUN) ||
                    (state_q == ST_BYPASS);

  seq_ramp #(.CW(CODE_W), .DIV(RAMP_DIV)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ramp_clr),
    .run       (ramp_run),
    .tick      (tick_us),
    .target    (target_code),
    .code      (ref_code),
    .at_target (ramp_done)
  );

  assign ocp_trip      = (ocp_cnt >= OCP_LIM);
  assign ss_expired    = (phase_cnt >= SS_LIM);
  assign retry_expired = (phase_cnt >= RT_LIM);
  assign hard_fault    = uvlo || otp;

  // Next-state: enable low dominates, then hard faults, then overcurrent,
  // then completion, then the soft-start deadline.
  always_comb begin
    state_d = state_q;
    if (!en_pin) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = hard_fault ? ST_FAULT : ST_SOFT;
        end
        ST_SOFT: begin
          if (hard_fault || ocp_trip) begin
            state_d = ST_FAULT;
          end else if (ramp_done && out_ok) begin
            state_d = pass_thru ? ST_BYPASS : ST_RUN;
          end else if (ss_expired) begin
            state_d = ST_FAULT;
          end
        end
        ST_RUN: begin
          if (hard_fault || ocp_trip) begin
            state_d = ST_FAULT;
          end else if (pass_thru) begin
            state_d = ST_BYPASS;
          end
        end
        ST_BYPASS: begin
          if (hard_fault) begin
            state_d = ST_FAULT;
          end else if (!pass_thru) begin
            state_d = ST_RUN;
          end
        end
        ST_FAULT: begin
          if (retry_expired && !hard_fault) begin
            state_d = ST_SOFT;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  // Output decode from the registered state.
  always_comb begin
    unique case (state_q)
      ST_SOFT:   outs = '{sw_en: 1'b1, iso_req: 1'b0, dis_en: 1'b0, pg_pull_low: 1'b1};
      ST_RUN:    outs = '{sw_en: 1'b1, iso_req: 1'b0, dis_en: 1'b0, pg_pull_low: 1'b0};
      ST_BYPASS: outs = '{sw_en: 1'b0, iso_req: 1'b0, dis_en: 1'b0, pg_pull_low: 1'b0};
      ST_FAULT:  outs = '{sw_en: 1'b0, iso_req: 1'b1, dis_en: 1'b0, pg_pull_low: 1'b1};
      default:   outs = '{sw_en: 1'b0, iso_req: 1'b1, dis_en: 1'b1, pg_pull_low: 1'b0};
    endcase
  end

  assign sw_en       = outs.sw_en;
  assign iso_req     = outs.iso_req;
  assign dis_en      = outs.dis_en;
  assign pg_pull_low = outs.pg_pull_low;

endmodule

// File: rtl/reg_seq_ctrl_chk.sv
module reg_seq_ctrl_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_us,
  input logic              en_pin,
  input logic              uvlo,
  input logic              otp,
  input logic              ilim,
  input logic              out_ok,
  input logic              pass_thru,
  input logic [CODE_W-1:0] target_code,
  input logic              sw_en,
  input logic [CODE_W-1:0] ref_code,
  input logic              dis_en,
  input logic              iso_req,
  input logic              pg_pull_low
);

  // R2
  en_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |=> (dis_en && iso_req && !sw_en && !pg_pull_low));

  // R1
  switch_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> !iso_req);

  // R4
  pg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pg_pull_low) && !iso_req) |-> $past((ref_code == target_code) && out_ok));

  // R8
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iso_req) && $past(en_pin)) |-> (pg_pull_low && !dis_en && !sw_en && (ref_code == '0)));

  // R7
  hard_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && (uvlo || otp) && !iso_req) |=> (iso_req && pg_pull_low));

  // R3
  ramp_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sw_en) && sw_en) |-> ((ref_code == $past(ref_code)) ||
                                 (ref_code == $past(ref_code) + CODE_W'(1)) ||
                                 ($past(ref_code) == ref_code + CODE_W'(1))));

  // R10
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && !iso_req && ilim && pass_thru && en_pin && !uvlo && !otp) |=> (!sw_en && !iso_req));

  // R12
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && en_pin && !uvlo && !otp) |=> $stable(ref_code));

endmodule

bind reg_seq_ctrl reg_seq_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_us     (tick_us),
  .en_pin      (en_pin),
  .uvlo        (uvlo),
  .otp         (otp),
  .ilim        (ilim),
  .out_ok      (out_ok),
  .pass_thru   (pass_thru),
  .target_code (target_code),
  .sw_en       (sw_en),
  .ref_code    (ref_code),
  .dis_en      (dis_en),
  .iso_req     (iso_req),
  .pg_pull_low (pg_pull_low)
);

// File: tb/reg_seq_ctrl_bench.sv
module reg_seq_ctrl_bench;

  localparam int CW = 7;

  logic          clk;
  logic          rst_n;
  logic          tick_us;
  logic          en_pin;
  logic          uvlo;
  logic          otp;
  logic          ilim;
  logic          out_ok;
  logic          pass_thru;
  logic [CW-1:0] target_code;
  logic          sw_en;
  logic [CW-1:0] ref_code;
  logic          dis_en;
  logic          iso_req;
  logic          pg_pull_low;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  reg_seq_ctrl #(
    .CODE_W(CW), .SS_TICKS(1000), .OCP_TICKS(700),
    .RETRY_TICKS(30000), .RAMP_DIV(4)
  ) u_reg_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en_pin(en_pin),
    .uvlo(uvlo), .otp(otp), .ilim(ilim), .out_ok(out_ok),
    .pass_thru(pass_thru), .target_code(target_code), .sw_en(sw_en),
    .ref_code(ref_code), .dis_en(dis_en), .iso_req(iso_req),
    .pg_pull_low(pg_pull_low)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic outs(string req, bit sw, bit iso, bit dis, bit pgl);
    chk(req, "sw_en", int'(sw_en), int'(sw));
    chk(req, "iso_req", int'(iso_req), int'(iso));
    chk(req, "dis_en", int'(dis_en), int'(dis));
    chk(req, "pg_pull_low", int'(pg_pull_low), int'(pgl));
  endtask

  // Leaves the bench just after the edge that enters soft start (m = 0).
  task automatic begin_ss(int tgt, bit ok);
    en_pin = 1'b0; uvlo = 1'b0; otp = 1'b0; ilim = 1'b0; pass_thru = 1'b0;
    tick_us = 1'b1; target_code = CW'(tgt); out_ok = ok;
    step(3);
    en_pin = 1'b1;
    step(1);
  endtask

  task automatic reach_run(int tgt);
    begin_ss(tgt, 1'b1);
    step(tgt * 4 + 1);
  endtask

  task automatic t_reset;
    outs("R1", 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1", "ref_code", int'(ref_code), 0);
  endtask

  task automatic t_ramp;
    begin_ss(10, 1'b1);
    outs("R3", 1'b1, 1'b0, 1'b0, 1'b1);
    step(20);
    chk("R3", "ref_code mid ramp", int'(ref_code), 5);
    step(20);
    chk("R4", "pg still low at target", int'(pg_pull_low), 1);
    step(1);
    outs("R4", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ss_timeout;
    begin_ss(10, 1'b0);
    step(1000);
    chk("R5", "iso_req before expiry", int'(iso_req), 0);
    step(1);
    outs("R5", 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8", "ref_code in fault", int'(ref_code), 0);
    en_pin = 1'b0;
    step(1);
    outs("R2", 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_ss_tie;
    begin_ss(10, 1'b0);
    step(1000);
    out_ok = 1'b1;
    step(1);
    outs("R5", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_track;
    reach_run(10);
    target_code = 7'd12;
    step(4);
    chk("R11", "ref_code up 1", int'(ref_code), 11);
    step(4);
    chk("R11", "ref_code up 2", int'(ref_code), 12);
    step(4);
    chk("R11", "ref_code holds", int'(ref_code), 12);
    target_code = 7'd11;
    step(4);
    chk("R11", "ref_code down", int'(ref_code), 11);
  endtask

  task automatic t_ocp;
    reach_run(10);
    ilim = 1'b1;
    step(500);
    ilim = 1'b0;
    step(1);
    ilim = 1'b1;
    step(700);
    chk("R6", "sw_en before window ends", int'(sw_en), 1);
    step(1);
    outs("R6", 1'b0, 1'b1, 1'b0, 1'b1);
    ilim = 1'b0;
  endtask

  task automatic t_coincide;
    reach_run(10);
    ilim = 1'b1;
    step(700);
    en_pin = 1'b0;
    step(1);
    outs("R2", 1'b0, 1'b1, 1'b1, 1'b0);
    ilim = 1'b0;
  endtask

  task automatic t_hard;
    reach_run(10);
    uvlo = 1'b1;
    step(1);
    outs("R7", 1'b0, 1'b1, 1'b0, 1'b1);
    begin_ss(10, 1'b1);
    step(5);
    otp = 1'b1;
    step(1);
    outs("R7", 1'b0, 1'b1, 1'b0, 1'b1);
    otp = 1'b0;
  endtask

  task automatic t_bypass;
    reach_run(10);
    pass_thru = 1'b1;
    step(1);
    outs("R10", 1'b0, 1'b0, 1'b0, 1'b0);
    ilim = 1'b1;
    step(800);
    outs("R10", 1'b0, 1'b0, 1'b0, 1'b0);
    ilim = 1'b0;
    pass_thru = 1'b0;
    step(1);
    outs("R10", 1'b1, 1'b0, 1'b0, 1'b0);
    pass_thru = 1'b1;
    step(1);
    otp = 1'b1;
    step(1);
    outs("R7", 1'b0, 1'b1, 1'b0, 1'b1);
    otp = 1'b0;
    pass_thru = 1'b0;
  endtask

  task automatic t_retry;
    reach_run(10);
    uvlo = 1'b1;
    step(1);
    uvlo = 1'b0;
    step(30000);
    chk("R9", "iso_req before retry", int'(iso_req), 1);
    step(1);
    outs("R9", 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9", "ref_code restart", int'(ref_code), 0);
    otp = 1'b1;
    step(1);
    step(30005);
    chk("R9", "iso_req held by otp", int'(iso_req), 1);
    chk("R9", "sw_en held by otp", int'(sw_en), 0);
    otp = 1'b0;
    step(1);
    chk("R9", "sw_en after otp clears", int'(sw_en), 1);
  endtask

  task automatic t_tick_gate;
    begin_ss(10, 1'b0);
    step(8);
    chk("R12", "ref_code before gate", int'(ref_code), 2);
    tick_us = 1'b0;
    step(2000);
    chk("R12", "ref_code frozen", int'(ref_code), 2);
    chk("R12", "no timeout iso_req", int'(iso_req), 0);
    tick_us = 1'b1;
    step(4);
    chk("R12", "ref_code resumes", int'(ref_code), 3);
  endtask

  initial begin
    rst_n = 1'b0; tick_us = 1'b1; en_pin = 1'b0; uvlo = 1'b0; otp = 1'b0;
    ilim = 1'b0; out_ok = 1'b0; pass_thru = 1'b0; target_code = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_ramp();
    t_ss_timeout();
    t_ss_tie();
    t_track();
    t_ocp();
    t_coincide();
    t_hard();
    t_bypass();
    t_retry();
    t_tick_gate();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule